// File: doc/BRIEF.md
# Byte-Lane Data Mask Pipeline

This block sits in the data path of a synchronous DRAM and turns per-byte mask inputs into two kinds of control. In a write cycle the mask acts at once: each byte lane of the incoming word is passed to the array, with its byte write-enable raised, only when that lane's mask bit is low. A masked lane is zeroed on the write data output and its write-enable stays low.

In a read, the same mask bits act as output-enable controls, but two clock cycles later. The block samples the mask together with a read-burst flag into a short pipeline. The stage at the far end drives one output enable per lane, and these enables gate the read data onto the output. The pipeline advances only on clock edges where clock-enable is high, so a suspended clock leaves the read timing where it was. The lane width is fixed at eight bits. The data width is a parameter, so a 16-bit build has two mask bits and an 8-bit build has one mask bit that covers the whole word.

Top module: `bytemask_lane_ctrl`

## Requirements
- R1: Mask bit 1 governs data bits 15 to 8 and mask bit 0 governs bits 7 to 0; in general mask bit i governs bits 8i+7 down to 8i.
- R2: `byte_we_o[i]` is high in the same cycle exactly when `wr_en` is high, `cke` is high and `mask_i[i]` is low, with no register in the path.
- R3: On `wdata_o`, a lane carries the matching byte of `wdata_i` when its write-enable is high and is zero otherwise.
- R4: During the cycle that ends at edge k+2, `lane_oe_o[i]` equals `rd_en` AND NOT `mask_i[i]` as sampled at edge k, provided `cke` was high at edges k and k+1. A high mask bit turns the lane off and a low mask bit turns it on.
- R5: An edge at which `cke` is low does not advance the read pipeline, so `lane_oe_o` keeps its value. In a cycle where `cke` is low, no write-enable is raised.
- R6: All output enables are low after reset. They are also low whenever the read-burst flag held in the pipeline's final stage is low.
- R7: On `rdq_o`, a lane carries the matching byte of `rdata_i` when its output enable is high and is zero otherwise.
- R8: With `DATA_W` = 8 the block has a single mask bit, and that bit controls the whole word in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock-enable; low suspends the read pipeline and blocks writes |
| wr_en | input | 1 | Write cycle indicator |
| rd_en | input | 1 | Read burst active, sampled together with the mask |
| mask_i | input | DATA_W/8 | Per-lane mask, bit i for byte lane i |
| wdata_i | input | DATA_W | Write data from the bus |
| rdata_i | input | DATA_W | Read data from the array |
| byte_we_o | output | DATA_W/8 | Per-lane write-enable to the array |
| wdata_o | output | DATA_W | Write data with masked lanes zeroed |
| lane_oe_o | output | DATA_W/8 | Per-lane output-driver enable |
| rdq_o | output | DATA_W | Read data with disabled lanes zeroed |

## Verification
The bench builds two instances that share the same stimulus: the default 16-bit block with a read latency of two, and an 8-bit block. The 16-bit build exercises the lane mapping, since the two mask bits can disagree, and the two-edge read delay across runs of suspended clock. The 8-bit build makes sure a single mask bit gates the whole word in both modes. A queue-based reference model, advanced only on enabled edges, predicts every output of both instances on every cycle.

// File: rtl/bytemask_pkg.sv
package bytemask_pkg;
   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned MAX_LANES = 16;
   localparam int unsigned MAX_LAT   = 8;
endpackage

// File: rtl/bytemask_wr_gate.sv
module bytemask_wr_gate
   import bytemask_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   localparam int unsigned LANES = DATA_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              wr_en,
   input  logic [LANES-1:0]  mask_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [LANES-1:0]  byte_we_o,
   output logic [DATA_W-1:0] wdata_o
);
   logic wr_live;
   assign wr_live = wr_en & cke;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign byte_we_o[g] = wr_live & ~mask_i[g];
      assign wdata_o[g*BYTE_W +: BYTE_W] =
         byte_we_o[g] ? wdata_i[g*BYTE_W +: BYTE_W] : '0;
   end

   AST_NO_MASKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_we_o & mask_i) == '0); // R2
   AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && cke) |-> byte_we_o == '0); // R5
   AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      byte_we_o == '0 |-> wdata_o == '0); // R3
endmodule

// File: rtl/bytemask_rd_pipe.sv
module bytemask_rd_pipe
   import bytemask_pkg::*;
#(
   parameter int unsigned LANES    = 2,
   parameter int unsigned READ_LAT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke,
   input  logic             rd_en,
   input  logic [LANES-1:0] mask_i,
   output logic [LANES-1:0] lane_oe_o
);
   localparam int unsigned STG_W = LANES + 1;
   localparam int unsigned LAST  = READ_LAT - 1;
   localparam logic [STG_W-1:0] IDLE = {1'b0, {LANES{1'b1}}};

   logic [STG_W-1:0] stg [READ_LAT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < READ_LAT; i++) stg[i] <= IDLE;
      end else if (cke) begin
         stg[0] <= {rd_en, mask_i};
         for (int i = 1; i < READ_LAT; i++) stg[i] <= stg[i-1];
      end
   end

   assign lane_oe_o = stg[LAST][LANES] ? ~stg[LAST][LANES-1:0] : '0;

   AST_CKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> $stable(lane_oe_o)); // R5
   AST_OE_AFTER_RESET: assert property (@(posedge clk)
      !rst_n |=> lane_oe_o == '0); // R6
endmodule

// File: rtl/bytemask_rd_drive.sv
module bytemask_rd_drive
   import bytemask_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   localparam int unsigned LANES = DATA_W / BYTE_W
) (
   input  logic [DATA_W-1:0] rdata_i,
   input  logic [LANES-1:0]  lane_oe_i,
   output logic [DATA_W-1:0] rdq_o
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign rdq_o[g*BYTE_W +: BYTE_W] =
         lane_oe_i[g] ? rdata_i[g*BYTE_W +: BYTE_W] : '0;
   end
endmodule

// File: rtl/bytemask_lane_ctrl.sv
module bytemask_lane_ctrl
   import bytemask_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned READ_LAT = 2,
   localparam int unsigned LANES   = DATA_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [LANES-1:0]  mask_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [LANES-1:0]  byte_we_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic [LANES-1:0]  lane_oe_o,
   output logic [DATA_W-1:0] rdq_o
);
   if (DATA_W % BYTE_W != 0 || DATA_W == 0) begin : g_bad_width
      $error("DATA_W must be a nonzero multiple of the lane width");
   end
   if (LANES > MAX_LANES) begin : g_bad_lanes
      $error("too many byte lanes");
   end
   if (READ_LAT < 1 || READ_LAT > MAX_LAT) begin : g_bad_lat
      $error("READ_LAT out of range");
   end

   bytemask_wr_gate #(.DATA_W(DATA_W)) wr_gate_i (
      .clk(clk), .rst_n(rst_n), .cke(cke), .wr_en(wr_en),
      .mask_i(mask_i), .wdata_i(wdata_i),
      .byte_we_o(byte_we_o), .wdata_o(wdata_o)
   );

   bytemask_rd_pipe #(.LANES(LANES), .READ_LAT(READ_LAT)) rd_pipe_i (
      .clk(clk), .rst_n(rst_n), .cke(cke), .rd_en(rd_en),
      .mask_i(mask_i), .lane_oe_o(lane_oe_o)
   );

   bytemask_rd_drive #(.DATA_W(DATA_W)) rd_drive_i (
      .rdata_i(rdata_i), .lane_oe_i(lane_oe_o), .rdq_o(rdq_o)
   );

   AST_RDQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      lane_oe_o == '0 |-> rdq_o == '0); // R7
endmodule

// File: tb/bytemask_lane_ctrl_tb_top.sv
module bytemask_lane_ctrl_tb_top;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        cke = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0]  mask = 2'b11;
   logic [15:0] wdata = '0, rdata = '0;

   logic [1:0]  we16, oe16;
   logic [15:0] wd16, rq16;
   logic [0:0]  we8, oe8;
   logic [7:0]  wd8, rq8;

   int checks = 0, errors = 0;
   logic [2:0] q[$];

   bytemask_lane_ctrl #(.DATA_W(16), .READ_LAT(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .cke(cke), .wr_en(wr_en), .rd_en(rd_en),
      .mask_i(mask), .wdata_i(wdata), .rdata_i(rdata),
      .byte_we_o(we16), .wdata_o(wd16), .lane_oe_o(oe16), .rdq_o(rq16));

   bytemask_lane_ctrl #(.DATA_W(8), .READ_LAT(2)) dut8_i (
      .clk(clk), .rst_n(rst_n), .cke(cke), .wr_en(wr_en), .rd_en(rd_en),
      .mask_i(mask[0:0]), .wdata_i(wdata[7:0]), .rdata_i(rdata[7:0]),
      .byte_we_o(we8), .wdata_o(wd8), .lane_oe_o(oe8), .rdq_o(rq8));

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] lanes16(logic [1:0] en, logic [15:0] d);
      return {en[1] ? d[15:8] : 8'h00, en[0] ? d[7:0] : 8'h00};
   endfunction

   // compare all outputs against the model
   task automatic compare();
      logic [1:0] ewe, eoe;
      logic [2:0] tail;
      tail = q[q.size()-1];
      ewe  = (wr_en && cke) ? ~mask : 2'b00;
      eoe  = tail[2] ? ~tail[1:0] : 2'b00;
      chk("R2 we16", {14'd0, we16}, {14'd0, ewe});
      chk("R3 wdata16", wd16, lanes16(ewe, wdata));
      chk("R4 oe16", {14'd0, oe16}, {14'd0, eoe});
      chk("R7 rdq16", rq16, lanes16(eoe, rdata));
      chk("R8 we8", {15'd0, we8}, {15'd0, ewe[0]});
      chk("R8 wdata8", {8'd0, wd8}, {8'd0, ewe[0] ? wdata[7:0] : 8'h00});
      chk("R8 oe8", {15'd0, oe8}, {15'd0, eoe[0]});
      chk("R8 rdq8", {8'd0, rq8}, {8'd0, eoe[0] ? rdata[7:0] : 8'h00});
   endtask

   task automatic model_edge();
      @(posedge clk);
      if (!rst_n) begin
         q = '{3'b011, 3'b011};
      end else if (cke) begin
         q.push_front({rd_en, mask});
         void'(q.pop_back());
      end
   endtask

   task automatic cyc(logic c, logic w, logic r, logic [1:0] m);
      @(negedge clk);
      cke = c; wr_en = w; rd_en = r; mask = m;
      wdata = 16'($urandom); rdata = 16'($urandom);
      #1 compare();
      model_edge();
   endtask

   initial begin
      int wd;
      wd = 0;
      while (wd < 20000) begin @(posedge clk); wd++; end
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      q = '{3'b011, 3'b011};
      repeat (3) model_edge();
      @(negedge clk);
      // R6: reset state, even with a read requested
      rd_en = 1'b1; mask = 2'b00; cke = 1'b1; rdata = 16'hFFFF;
      #1 chk("R6 reset oe16", {14'd0, oe16}, 16'd0);
      chk("R6 reset rdq16", rq16, 16'd0);
      model_edge();
      rst_n = 1'b1;
      // R1: lane mapping in write mode
      @(negedge clk);
      wr_en = 1'b1; rd_en = 1'b0; mask = 2'b10; wdata = 16'hA55A;
      #1 chk("R1 upper masked we", {14'd0, we16}, 16'h0001);
      chk("R1 upper masked data", wd16, 16'h005A);
      model_edge();
      @(negedge clk);
      mask = 2'b01;
      #1 chk("R1 lower masked we", {14'd0, we16}, 16'h0002);
      chk("R1 lower masked data", wd16, 16'hA500);
      model_edge();
      // R5: no write while clock suspended
      @(negedge clk);
      cke = 1'b0; mask = 2'b00;
      #1 chk("R5 we with cke low", {14'd0, we16}, 16'd0);
      model_edge();
      // writes with every mask
      for (int m = 0; m < 4; m++) cyc(1, 1, 0, 2'(m));
      // R4: read latency with a toggling mask
      cyc(1, 0, 1, 2'b00);
      cyc(1, 0, 1, 2'b01);
      cyc(1, 0, 1, 2'b10);
      cyc(1, 0, 1, 2'b11);
      cyc(1, 0, 1, 2'b00);
      // R5: suspend in mid burst, pipeline holds
      cyc(0, 0, 1, 2'b11);
      cyc(0, 0, 0, 2'b11);
      cyc(0, 0, 1, 2'b01);
      cyc(1, 0, 1, 2'b10);
      cyc(1, 0, 0, 2'b00);
      // R6: burst ends, enables drop
      cyc(1, 0, 0, 2'b00);
      cyc(1, 0, 0, 2'b00);
      cyc(1, 0, 0, 2'b00);
      // random mixed traffic
      for (int i = 0; i < 400; i++) begin
         logic [3:0] rv;
         rv = 4'($urandom);
         cyc(rv[3] | rv[2], rv[1] & ~rv[0], rv[0], 2'($urandom));
      end
      // mid-run reset
      @(negedge clk);
      rst_n = 1'b0; rd_en = 1'b1; mask = 2'b00; cke = 1'b1;
      model_edge();
      @(negedge clk);
      #1 chk("R6 oe after reset", {14'd0, oe16}, 16'd0);
      chk("R6 oe8 after reset", {15'd0, oe8}, 16'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule